// File: doc/BRIEF.md
# Vectored Interrupt Enable Controller

This block gathers six interrupt sources for a small microcontroller core and presents at most one of them to the CPU as a request with a fixed vector address. The sources are two active-low external pins, three timer flags, and one serial source. Timer 0 and timer 1 each give one flag. Timer 2 gives two flags: overflow and capture. The serial source is formed from a receive flag and a transmit flag. An 8-bit enable register holds one enable bit per source and a master gate. A separate trigger-mode register chooses, for each external pin, whether the pin is sensed by level or by its falling edge.

The CPU writes and reads both registers through a simple one-cycle port. The controller drives `irq_req` together with `irq_vec`. When the CPU raises `irq_ack` while a request is shown, the controller enters service. At that moment it clears the edge-latched flag of the granted source, but only if that source is a transition-mode external pin. The controller then holds off all further requests until `irq_ret` is pulsed. Timer and serial flags are never cleared by the controller: their owners clear them.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Register address 0 is the enable register. Its bit 7 is the master gate, bit 5 enables timer 2, bit 4 the serial source, bit 3 timer 1, bit 2 external pin 1, bit 1 timer 0 and bit 0 external pin 0. Register address 1 is the trigger-mode register, with bit 0 for pin 0 and bit 1 for pin 1 and all other bits reading 0. A write takes effect at the next clock edge, and `reg_rdata` shows the selected register combinationally.
- R2: Bit 6 of the enable register is reserved. It always reads 0, and writing 1 to it has no effect.
- R3: When the master gate (bit 7) is 0, `irq_req` stays 0 whatever the other enable bits and sources hold.
- R4: When the master gate is 1, a pending source can request only if its own enable bit is 1.
- R5: The vector addresses are fixed: external pin 0 at 0x0003, timer 0 at 0x000B, external pin 1 at 0x0013, timer 1 at 0x001B, serial at 0x0023, timer 2 at 0x002B.
- R6: When several enabled sources are pending, the one with the lowest vector address is presented.
- R7: With its mode bit at 0, an external pin is level sensed. The request is active while the pin is low, it drops as soon as the pin goes high, and nothing is latched.
- R8: With its mode bit at 1, a high-to-low change across two consecutive clock samples latches a request. The request stays latched after the pin returns high.
- R9: Acknowledging a transition-mode external pin clears its latch. Acknowledging a timer or serial source leaves that source's flag untouched.
- R10: The serial source is pending when either its receive flag or its transmit flag is high. The timer 2 source is pending when either its overflow flag or its capture flag is high.
- R11: After an acknowledge that is accepted while `irq_req` is high, no request is raised until an `irq_ret` pulse arrives.
- R12: After reset both registers read 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable register, 1 = trigger-mode register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_n | input | 2 | External interrupt pins, active low |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_cap | input | 1 | Timer 2 capture/reload flag |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the presented source |
| irq_ack | input | 1 | CPU acknowledge |
| irq_ret | input | 1 | Return-from-interrupt pulse |

## Verification
A corrupted enable or mode bit shows up in `reg_rdata` at once. It also shows up in `irq_req` or `irq_vec` in the same cycle that a source is pending, because the request path after the registers has no storage. A missed or stale edge latch shows up one edge after the pin falls, or one edge after an acknowledge, as a request that should or should not be present. A service flag stuck high or low shows up as a missing or extra request on the first cycle after the acknowledge or after the return pulse.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC   = 6;
  localparam int NEXT   = 2;
  localparam int IDX_W  = $clog2(NSRC);

  typedef enum logic [IDX_W-1:0] {
    SRC_EX0 = 3'd0,
    SRC_TM0 = 3'd1,
    SRC_EX1 = 3'd2,
    SRC_TM1 = 3'd3,
    SRC_SER = 3'd4,
    SRC_TM2 = 3'd5
  } src_e;

  // slot of external pin k in the priority order
  function automatic logic [IDX_W-1:0] ext_slot(input int k);
    return IDX_W'(2 * k);
  endfunction

  // vector address of priority slot idx
  function automatic logic [15:0] vec_of(input logic [IDX_W-1:0] idx,
                                         input int base, input int stride);
    int v;
    v = base + stride * int'(idx);
    return v[15:0];
  endfunction

  // lowest set bit of a pending mask
  function automatic logic [IDX_W-1:0] lowest_idx(input logic [NSRC-1:0] act);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int REG_W   = 8,
  parameter int RSV_BIT = 6,
  parameter int NEXT    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic [NEXT-1:0]  mode_q,
  output logic [REG_W-1:0] rdata
);
  localparam logic [REG_W-1:0] EN_MASK = ~(REG_W'(1) << RSV_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
    end else if (wr) begin
      if (!addr) en_q   <= wdata & EN_MASK;
      else       mode_q <= wdata[NEXT-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) rdata = en_q;
    else       rdata[NEXT-1:0] = mode_q;
  end
endmodule

// File: rtl/irq_edge_sense.sv
module irq_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic mode,
  input  logic clr,
  output logic req,
  output logic fall,
  output logic latch
);
  logic last_q;
  logic latch_d;

  assign fall = last_q & ~pin_n;

  always_comb begin
    if (mode) latch_d = (latch & ~clr) | fall;
    else      latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      latch  <= 1'b0;
    end else begin
      last_q <= pin_n;
      latch  <= latch_d;
    end
  end

  assign req = mode ? latch : ~pin_n;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_vec_pkg::*;
#(
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic [NSRC-1:0]  act,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [15:0]      vec
);
  assign any = |act;
  assign idx = lowest_idx(act);
  assign vec = any ? vec_of(idx, VEC_BASE, VEC_STRIDE) : 16'h0000;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int GATE_BIT   = 7,
  parameter int RSV_BIT    = 6,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NEXT-1:0]  ext_n,
  input  logic             tmr0_flag,
  input  logic             tmr1_flag,
  input  logic             tmr2_ovf,
  input  logic             tmr2_cap,
  input  logic             ser_rx,
  input  logic             ser_tx,
  output logic             irq_req,
  output logic [15:0]      irq_vec,
  input  logic             irq_ack,
  input  logic             irq_ret
);
  logic [REG_W-1:0] en_q;
  logic [NEXT-1:0]  mode_q;
  logic [NEXT-1:0]  ext_req, ext_fall, ext_latch, ext_clr;
  logic [NSRC-1:0]  src_pend, act;
  logic             any_act, grant, in_svc;
  logic [IDX_W-1:0] win_idx;
  logic [15:0]      win_vec;

  irq_cfg_regs #(.REG_W(REG_W), .RSV_BIT(RSV_BIT), .NEXT(NEXT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .en_q(en_q), .mode_q(mode_q), .rdata(reg_rdata)
  );

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    assign ext_clr[k] = grant && (win_idx == ext_slot(k));
    irq_edge_sense u_sense (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_n[k]), .mode(mode_q[k]),
      .clr(ext_clr[k]), .req(ext_req[k]), .fall(ext_fall[k]),
      .latch(ext_latch[k])
    );
  end

  always_comb begin
    src_pend          = '0;
    src_pend[SRC_EX0] = ext_req[0];
    src_pend[SRC_TM0] = tmr0_flag;
    src_pend[SRC_EX1] = ext_req[1];
    src_pend[SRC_TM1] = tmr1_flag;
    src_pend[SRC_SER] = ser_rx | ser_tx;
    src_pend[SRC_TM2] = tmr2_ovf | tmr2_cap;
  end

  assign act = src_pend & en_q[NSRC-1:0] & {NSRC{en_q[GATE_BIT]}};

  irq_prio_pick #(.VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_pick (
    .act(act), .any(any_act), .idx(win_idx), .vec(win_vec)
  );

  assign irq_req = any_act & ~in_svc;
  assign irq_vec = win_vec;
  assign grant   = irq_req & irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_svc <= 1'b0;
    else if (grant)   in_svc <= 1'b1;
    else if (irq_ret) in_svc <= 1'b0;
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic [7:0]  en_q,
  input logic [1:0]  mode_q,
  input logic [5:0]  act,
  input logic        in_svc,
  input logic        grant,
  input logic [1:0]  ext_fall,
  input logic [1:0]  ext_latch
);
  logic [15:0] slot;
  logic [5:0]  below;

  always_comb begin
    slot  = (irq_vec - 16'd3) >> 3;
    below = 6'((7'd1 << slot[2:0]) - 7'd1);
  end

  AST_RSV_ZERO:      assert property (@(posedge clk) disable iff (!rst_n) en_q[6] == 1'b0); // R2
  AST_GLOBAL_GATE:   assert property (@(posedge clk) disable iff (!rst_n) !en_q[7] |-> !irq_req); // R3
  AST_OWN_ENABLE:    assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> en_q[slot[2:0]]); // R4
  AST_VEC_ALIGN:     assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h002B)); // R5
  AST_LOWEST_WINS:   assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> ((act & below) == 6'd0)); // R6
  AST_LEVEL_NOLAT0:  assert property (@(posedge clk) disable iff (!rst_n) !mode_q[0] |=> !ext_latch[0]); // R7
  AST_LEVEL_NOLAT1:  assert property (@(posedge clk) disable iff (!rst_n) !mode_q[1] |=> !ext_latch[1]); // R7
  AST_EDGE_SETS0:    assert property (@(posedge clk) disable iff (!rst_n) (mode_q[0] && ext_fall[0]) |=> ext_latch[0]); // R8
  AST_ACK_CLEARS0:   assert property (@(posedge clk) disable iff (!rst_n) (grant && irq_vec == 16'h0003 && mode_q[0] && !ext_fall[0]) |=> !ext_latch[0]); // R9
  AST_NO_NEST:       assert property (@(posedge clk) disable iff (!rst_n) in_svc |-> !irq_req); // R11
  AST_ACK_ENTERS:    assert property (@(posedge clk) disable iff (!rst_n) grant |=> in_svc); // R11
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
  .en_q(en_q), .mode_q(mode_q), .act(act), .in_svc(in_svc), .grant(grant),
  .ext_fall(ext_fall), .ext_latch(ext_latch)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic [1:0]  ext_n = 2'b11;
  logic        tmr0_flag = 0, tmr1_flag = 0, tmr2_ovf = 0, tmr2_cap = 0;
  logic        ser_rx = 0, ser_tx = 0;
  logic        irq_req, irq_ack = 0, irq_ret = 0;
  logic [15:0] irq_vec;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_n(ext_n),
    .tmr0_flag(tmr0_flag), .tmr1_flag(tmr1_flag), .tmr2_ovf(tmr2_ovf),
    .tmr2_cap(tmr2_cap), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_reset();
    ext_n = 2'b11; tmr0_flag = 0; tmr1_flag = 0; tmr2_ovf = 0; tmr2_cap = 0;
    ser_rx = 0; ser_tx = 0; irq_ack = 0; irq_ret = 0; reg_wr = 0;
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
  endtask

  // expected vector of priority slot, from R5
  function automatic logic [15:0] exp_vec(input int i);
    return 16'(8 * i + 3);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd_reg(1'b0, d); chk("R12 enable reg", d, 8'h00);
    rd_reg(1'b1, d); chk("R12 mode reg", d, 8'h00);
    chk("R12 req", irq_req, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    do_reset();
    wr_reg(1'b0, 8'hFF); rd_reg(1'b0, d); chk("R2 reserved bit", d, 8'hBF);
    wr_reg(1'b0, 8'h2A); rd_reg(1'b0, d); chk("R1 enable readback", d, 8'h2A);
    wr_reg(1'b1, 8'hFF); rd_reg(1'b1, d); chk("R1 mode readback", d, 8'h03);
    rd_reg(1'b0, d); chk("R1 enable kept", d, 8'h2A);
  endtask

  task automatic t_gate();
    do_reset();
    wr_reg(1'b0, 8'h3F); tmr0_flag = 1; ext_n = 2'b00; ser_rx = 1; tick();
    chk("R3 gate off", irq_req, 0);
    ext_n = 2'b11; ser_rx = 0;
    wr_reg(1'b0, 8'h88); tick();
    chk("R4 own enable off", irq_req, 0);
    wr_reg(1'b0, 8'h82); tick();
    chk("R4 own enable on", irq_req, 1);
    chk("R5 timer0 vec", irq_vec, 16'h000B);
    tmr0_flag = 0;
  endtask

  task automatic drive_src(input int i, input int alt, input logic v);
    case (i)
      0: ext_n[0] = ~v;
      1: tmr0_flag = v;
      2: ext_n[1] = ~v;
      3: tmr1_flag = v;
      4: if (alt != 0) ser_tx = v; else ser_rx = v;
      default: if (alt != 0) tmr2_cap = v; else tmr2_ovf = v;
    endcase
  endtask

  task automatic t_vectors();
    do_reset();
    for (int i = 0; i < 6; i++) begin
      for (int alt = 0; alt < 2; alt++) begin
        wr_reg(1'b0, 8'h80 | 8'(1 << i));
        drive_src(i, alt, 1'b1); tick();
        chk(i >= 4 ? "R10 combined flag req" : "R5 source req", irq_req, 1);
        chk("R5 vector", irq_vec, exp_vec(i));
        drive_src(i, alt, 1'b0); tick();
        chk("R10 flag dropped", irq_req, 0);
      end
    end
  endtask

  task automatic t_prio();
    do_reset();
    wr_reg(1'b0, 8'hBF);
    tmr1_flag = 1; ser_tx = 1; tmr0_flag = 1; tmr2_ovf = 1; tick();
    chk("R6 lowest wins", irq_vec, 16'h000B);
    tmr0_flag = 0; tick();
    chk("R6 next lowest", irq_vec, 16'h001B);
    ext_n[0] = 1'b0; tick();
    chk("R6 ext0 overtakes", irq_vec, 16'h0003);
    ext_n[0] = 1'b1; tmr1_flag = 0; tick();
    chk("R6 serial next", irq_vec, 16'h0023);
    ser_tx = 0; tmr2_ovf = 0;
  endtask

  task automatic t_level();
    do_reset();
    wr_reg(1'b0, 8'h84);
    ext_n[1] = 1'b0; tick();
    chk("R7 level low req", irq_req, 1);
    chk("R7 level vec", irq_vec, 16'h0013);
    ext_n[1] = 1'b1; #1;
    chk("R7 level released", irq_req, 0);
    tick();
    chk("R7 no latch", irq_req, 0);
  endtask

  task automatic t_edge_service();
    do_reset();
    wr_reg(1'b1, 8'h01);
    wr_reg(1'b0, 8'h83);
    tick();
    chk("R8 idle no req", irq_req, 0);
    ext_n[0] = 1'b0; tick();
    ext_n[0] = 1'b1; tick();
    chk("R8 latched after release", irq_req, 1);
    chk("R8 vec", irq_vec, 16'h0003);
    irq_ack = 1; tick(); irq_ack = 0;
    chk("R11 in service no req", irq_req, 0);
    tmr0_flag = 1; tick();
    chk("R11 timer held off", irq_req, 0);
    irq_ret = 1; tick(); irq_ret = 0;
    chk("R9 ext latch cleared", irq_vec, 16'h000B);
    chk("R11 req after return", irq_req, 1);
    irq_ack = 1; tick(); irq_ack = 0;
    chk("R11 timer in service", irq_req, 0);
    irq_ret = 1; tick(); irq_ret = 0;
    chk("R9 timer flag kept", irq_req, 1);
    chk("R9 timer vec", irq_vec, 16'h000B);
    tmr0_flag = 0; tick();
    chk("R9 peripheral cleared", irq_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_regs();
    t_gate();
    t_vectors();
    t_prio();
    t_level();
    t_edge_service();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule